// File: doc/BRIEF.md
# PLL Output Rate Calculator

This unit works out the output frequency of a phase-locked loop from the reference frequency and the raw contents of two divider configuration words. It takes the feedback multiplier, the pre-divider, the power-of-two post-divider and, in fractional mode, a signed 16-bit fractional multiplier. From these it forms a 64-bit numerator and a denominator, then runs a restoring shift-subtract division that yields one quotient bit per clock. The result is truncated toward zero.

A client raises `start_i` for one cycle with the operands present. The unit captures them and runs for a fixed number of cycles, then presents the rate together with a one-cycle `done_o` pulse. A zero pre-divider skips the division. In that case the unit reports zero with an error flag in the cycle after acceptance.

Top module: `pll_rate_calc`

## Requirements
- R1: The multiplier M is taken from bits 21:12 of `div_word0_i`, the pre-divider P from bits 9:4 and the post-divider S from bits 2:0. The fractional term K is taken from bits 15:0 of `div_word1_i`. All other bits of both words have no effect on the result.
- R2: With `frac_mode_i` = 0 the result is floor(Fin × M / (P × 2^S)), where Fin is `ref_rate_i`.
- R3: With `frac_mode_i` = 1 the result is floor(Fin × (M × 65536 + K) / (P × 65536 × 2^S)), with K read as signed two's complement.
- R4: In fractional mode, if M × 65536 + K is negative, the result is 0 and `div_err_o` is 0.
- R5: If P is 0, `done_o` rises in the cycle after the accepting edge, with `rate_o` = 0 and `div_err_o` = 1.
- R6: For P ≠ 0, `busy_o` is high for exactly 64 cycles after the accepting edge. `done_o` is then high for one cycle with `div_err_o` = 0, and `busy_o` and `done_o` are never high together.
- R7: While `busy_o` is high, `start_i` is ignored. The operands captured at acceptance decide the result even if the inputs change later.
- R8: A quotient that does not fit in 32 bits is reported as 32'hFFFFFFFF.
- R9: After reset, `busy_o`, `done_o`, `rate_o` and `div_err_o` are all 0.
- R10: `rate_o` and `div_err_o` change only in a cycle in which `done_o` is high, and they hold their values until the next such cycle.
- R11: A `start_i` raised in the cycle in which `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to compute; sampled only when idle |
| frac_mode_i | input | 1 | 0 = integer formula, 1 = fractional formula |
| ref_rate_i | input | 32 | Reference frequency Fin |
| div_word0_i | input | 32 | Divider word holding M, P and S |
| div_word1_i | input | 32 | Divider word holding signed K |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result valid pulse |
| rate_o | output | 32 | Computed rate, held between results |
| div_err_o | output | 1 | Last result came from a zero pre-divider |

## Verification
Two functions can fall in the same cycle: the result being presented and a new request being accepted. The bench raises `start_i` in the very cycle in which it first sees `done_o`. Some of these back-to-back requests use a zero pre-divider, so a second `done_o` follows at once. A behavioural model that tracks idle and busy cycles with plain counters judges each case. It compares every output on every clock, so a request that is dropped, or accepted one cycle late, shows up as a mismatch in latency or in value.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
    // Field positions inside the divider words (decoded by the divider hardware)
    localparam int M_LSB = 12;
    localparam int M_W   = 10;
    localparam int P_LSB = 4;
    localparam int P_W   = 6;
    localparam int S_LSB = 0;
    localparam int S_W   = 3;
    localparam int K_LSB = 0;
    localparam int K_W   = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } calc_state_e;
endpackage

// File: rtl/pll_field_unpack.sv
module pll_field_unpack
    import pll_rate_pkg::*;
#(
    parameter int REF_W  = 32,
    parameter int WORD_W = 32,
    parameter int NUM_W  = 64,
    parameter int DEN_W  = P_W + K_W + (2 ** S_W) - 1
) (
    input  logic              frac_i,
    input  logic [REF_W-1:0]  ref_i,
    input  logic [WORD_W-1:0] word0_i,
    input  logic [WORD_W-1:0] word1_i,
    output logic [NUM_W-1:0]  num_o,
    output logic [DEN_W-1:0]  den_o,
    output logic              pzero_o
);
    localparam int MULT_W = M_W + K_W + 1;
    localparam int MAG_W  = MULT_W - 1;

    logic [M_W-1:0]           m_fld;
    logic [P_W-1:0]           p_fld;
    logic [S_W-1:0]           s_fld;
    logic [K_W-1:0]           k_fld;
    logic signed [MULT_W-1:0] k_ext;
    logic signed [MULT_W-1:0] m_scaled;
    logic signed [MULT_W-1:0] mult;
    logic [MAG_W-1:0]         mag;
    logic [DEN_W-1:0]         p_base;

    assign m_fld = word0_i[M_LSB +: M_W];
    assign p_fld = word0_i[P_LSB +: P_W];
    assign s_fld = word0_i[S_LSB +: S_W];
    assign k_fld = word1_i[K_LSB +: K_W];

    always_comb begin
        k_ext = {{(MULT_W - K_W){k_fld[K_W-1]}}, k_fld};
        if (frac_i) begin
            m_scaled = {1'b0, m_fld, {K_W{1'b0}}};
            mult     = m_scaled + k_ext;
            p_base   = DEN_W'({p_fld, {K_W{1'b0}}});
        end else begin
            m_scaled = {{(MULT_W - M_W){1'b0}}, m_fld};
            mult     = m_scaled;
            p_base   = DEN_W'(p_fld);
        end
        // a negative effective multiplier clamps to zero
        mag     = mult[MULT_W-1] ? '0 : mult[MAG_W-1:0];
        num_o   = {{(NUM_W - REF_W){1'b0}}, ref_i} * {{(NUM_W - MAG_W){1'b0}}, mag};
        den_o   = p_base << s_fld;
        pzero_o = (p_fld == '0);
    end
endmodule

// File: rtl/pll_div_step.sv
module pll_div_step #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 29
) (
    input  logic [NUM_W-1:0] quo_i,
    input  logic [DEN_W-1:0] rem_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic [DEN_W-1:0] rem_o
);
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;

    always_comb begin
        trial = {rem_i, quo_i[NUM_W-1]};
        diff  = trial - {1'b0, den_i};
        if (trial >= {1'b0, den_i}) begin
            rem_o = diff[DEN_W-1:0];
            quo_o = {quo_i[NUM_W-2:0], 1'b1};
        end else begin
            rem_o = trial[DEN_W-1:0];
            quo_o = {quo_i[NUM_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_rate_pkg::*;
#(
    parameter int REF_W  = 32,
    parameter int WORD_W = 32,
    parameter int RATE_W = 32,
    parameter int NUM_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              frac_mode_i,
    input  logic [REF_W-1:0]  ref_rate_i,
    input  logic [WORD_W-1:0] div_word0_i,
    input  logic [WORD_W-1:0] div_word1_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              div_err_o
);
    localparam int DEN_W = P_W + K_W + (2 ** S_W) - 1;
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_W - 1);

    typedef struct packed {
        calc_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [NUM_W-1:0]  quo;
        logic [DEN_W-1:0]  rem;
        logic [DEN_W-1:0]  den;
        logic              done;
        logic              err;
        logic [RATE_W-1:0] rate;
    } calc_regs_t;

    calc_regs_t        regs_d, regs_q;
    logic [NUM_W-1:0]  num_w;
    logic [DEN_W-1:0]  den_w;
    logic              pzero_w;
    logic [NUM_W-1:0]  step_quo;
    logic [DEN_W-1:0]  step_rem;

    pll_field_unpack #(
        .REF_W (REF_W),
        .WORD_W(WORD_W),
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) i_unpack (
        .frac_i (frac_mode_i),
        .ref_i  (ref_rate_i),
        .word0_i(div_word0_i),
        .word1_i(div_word1_i),
        .num_o  (num_w),
        .den_o  (den_w),
        .pzero_o(pzero_w)
    );

    pll_div_step #(
        .NUM_W(NUM_W),
        .DEN_W(DEN_W)
    ) i_step (
        .quo_i(regs_q.quo),
        .rem_i(regs_q.rem),
        .den_i(regs_q.den),
        .quo_o(step_quo),
        .rem_o(step_rem)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (pzero_w) begin
                        regs_d.done = 1'b1;
                        regs_d.err  = 1'b1;
                        regs_d.rate = '0;
                    end else begin
                        regs_d.state = ST_RUN;
                        regs_d.cnt   = '0;
                        regs_d.quo   = num_w;
                        regs_d.rem   = '0;
                        regs_d.den   = den_w;
                    end
                end
            end
            ST_RUN: begin
                regs_d.quo = step_quo;
                regs_d.rem = step_rem;
                regs_d.cnt = regs_q.cnt + 1'b1;
                if (regs_q.cnt == LAST_STEP) begin
                    regs_d.state = ST_IDLE;
                    regs_d.done  = 1'b1;
                    regs_d.err   = 1'b0;
                    regs_d.rate  = (|step_quo[NUM_W-1:RATE_W]) ? '1
                                                               : step_quo[RATE_W-1:0];
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign busy_o    = (regs_q.state == ST_RUN);
    assign done_o    = regs_q.done;
    assign rate_o    = regs_q.rate;
    assign div_err_o = regs_q.err;
endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
    parameter int RATE_W = 32,
    parameter int NUM_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [RATE_W-1:0] rate_o,
    input logic              div_err_o
);
    localparam int CNT_W = $clog2(NUM_W + 2);

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (done_o) begin
            busy_cnt <= '0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_err_o) |-> (busy_cnt == CNT_W'(NUM_W)));

    p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_err_o) |-> (rate_o == '0));

    p_err_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_err_o) |-> !$past(busy_o));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(rate_o) && $stable(div_err_o)));

    p_no_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));
endmodule

bind pll_rate_calc pll_rate_calc_chk #(
    .RATE_W(RATE_W),
    .NUM_W (NUM_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rate_o   (rate_o),
    .div_err_o(div_err_o)
);

// File: tb/test_pll_rate_calc.sv
module test_pll_rate_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        frac_mode_i = 1'b0;
    logic [31:0] ref_rate_i = '0;
    logic [31:0] div_word0_i = '0;
    logic [31:0] div_word1_i = '0;
    logic        busy_o, done_o, div_err_o;
    logic [31:0] rate_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R9";

    pll_rate_calc i_pll_rate_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frac_mode_i(frac_mode_i),
        .ref_rate_i(ref_rate_i), .div_word0_i(div_word0_i), .div_word1_i(div_word1_i),
        .busy_o(busy_o), .done_o(done_o), .rate_o(rate_o), .div_err_o(div_err_o)
    );

    always #10 clk = ~clk;

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // independent arithmetic from the requirement formulas
    function automatic logic [31:0] ref_rate(input logic frac, input logic [31:0] fin,
                                             input logic [31:0] w0, input logic [31:0] w1,
                                             output logic err);
        longint          m, p, s, k, mult;
        longint unsigned num, den, q;
        m = longint'(w0[21:12]);
        p = longint'(w0[9:4]);
        s = longint'(w0[2:0]);
        k = longint'($signed(w1[15:0]));
        err = 1'b0;
        if (p == 0) begin
            err = 1'b1;
            return 32'h0;
        end
        if (frac) begin
            mult = m * 65536 + k;
            if (mult < 0) mult = 0;
            den = longint'(p * 65536) << s;
        end else begin
            mult = m;
            den = longint'(p) << s;
        end
        num = longint'({32'h0, fin}) * mult;
        q = num / den;
        if (q > 64'hFFFF_FFFF) return 32'hFFFF_FFFF;
        return q[31:0];
    endfunction

    // cycle model: plain counters, updated from the inputs at each edge
    logic        m_busy = 1'b0, m_done = 1'b0, m_err = 1'b0, p_err;
    logic [31:0] m_rate = '0, p_rate = '0;
    int          m_left = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_err = 1'b0; m_rate = '0; m_left = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 1'b0; m_done = 1'b1; m_rate = p_rate; m_err = 1'b0;
                end
            end else if (start_i) begin
                p_rate = ref_rate(frac_mode_i, ref_rate_i, div_word0_i, div_word1_i, p_err);
                if (p_err) begin
                    m_done = 1'b1; m_rate = '0; m_err = 1'b1;
                end else begin
                    m_busy = 1'b1; m_left = 64;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "busy_o", longint'(busy_o), longint'(m_busy));
            check(cur_req, "done_o", longint'(done_o), longint'(m_done));
            check(cur_req, "rate_o", longint'(rate_o), longint'(m_rate));
            check(cur_req, "div_err_o", longint'(div_err_o), longint'(m_err));
        end
    end

    function automatic logic [31:0] mkw0(input int m, input int p, input int s, input logic junk);
        logic [31:0] w;
        w = junk ? 32'hFFC0_0C08 : 32'h0;
        w[21:12] = m[9:0];
        w[9:4] = p[5:0];
        w[2:0] = s[2:0];
        return w;
    endfunction

    // drives at the current negedge; returns one negedge later
    task automatic launch(input logic frac, input logic [31:0] fin,
                          input logic [31:0] w0, input logic [31:0] w1);
        frac_mode_i = frac; ref_rate_i = fin; div_word0_i = w0; div_word1_i = w1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done_o && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_case(string req, input logic frac, input logic [31:0] fin,
                            input logic [31:0] w0, input logic [31:0] w1);
        logic        e_err;
        logic [31:0] e_rate;
        cur_req = req;
        e_rate = ref_rate(frac, fin, w0, w1, e_err);
        @(negedge clk);
        launch(frac, fin, w0, w1);
        wait_done();
        check(req, "result rate", longint'(rate_o), longint'(e_rate));
        check(req, "result err", longint'(div_err_o), longint'(e_err));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin : stim
        logic        e_err;
        logic [31:0] e_rate;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9", "busy_o", longint'(busy_o), 0);
        check("R9", "done_o", longint'(done_o), 0);
        check("R9", "rate_o", longint'(rate_o), 0);
        check("R9", "div_err_o", longint'(div_err_o), 0);

        // R2 integer formula, R1 with junk bits outside the fields
        run_case("R2", 1'b0, 32'd24_000_000, mkw0(300, 3, 2, 1'b0), 32'h0);
        check("R2", "600 MHz", longint'(rate_o), 64'd600_000_000);
        run_case("R1", 1'b0, 32'd24_000_000, mkw0(300, 3, 2, 1'b1), 32'hFFFF_0000);
        check("R1", "junk ignored", longint'(rate_o), 64'd600_000_000);
        run_case("R2", 1'b0, 32'd25_000_001, mkw0(7, 3, 0, 1'b0), 32'h0);
        run_case("R2", 1'b0, 32'd19_200_000, mkw0(1000, 63, 7, 1'b0), 32'h0);

        // R3 fractional, positive and negative K
        run_case("R3", 1'b1, 32'd24_000_000, mkw0(300, 3, 2, 1'b0), 32'h0000_03E8);
        run_case("R3", 1'b1, 32'd24_000_000, mkw0(300, 3, 2, 1'b1), 32'hABCD_FC18);
        run_case("R3", 1'b1, 32'd27_000_000, mkw0(1, 1, 0, 1'b0), 32'h0000_8000);

        // R4 negative effective multiplier
        run_case("R4", 1'b1, 32'd24_000_000, mkw0(0, 2, 1, 1'b0), 32'h0000_8001);
        check("R4", "clamped zero", longint'(rate_o), 0);

        // R5 zero pre-divider
        run_case("R5", 1'b0, 32'd24_000_000, mkw0(300, 0, 2, 1'b0), 32'h0);
        check("R5", "error flag", longint'(div_err_o), 1);

        // R8 saturation
        run_case("R8", 1'b0, 32'hFFFF_FFFF, mkw0(1023, 1, 0, 1'b0), 32'h0);
        check("R8", "saturated", longint'(rate_o), 64'hFFFF_FFFF);

        // R7: start and operand changes during a run are ignored
        cur_req = "R7";
        e_rate = ref_rate(1'b0, 32'd24_000_000, mkw0(300, 3, 2, 1'b0), 32'h0, e_err);
        @(negedge clk);
        launch(1'b0, 32'd24_000_000, mkw0(300, 3, 2, 1'b0), 32'h0);
        repeat (5) @(negedge clk);
        launch(1'b1, 32'd1, mkw0(5, 0, 1, 1'b0), 32'h1234);
        div_word0_i = mkw0(9, 9, 1, 1'b0);
        wait_done();
        check("R7", "first operands win", longint'(rate_o), longint'(e_rate));
        check("R7", "no error", longint'(div_err_o), 0);

        // R11: back-to-back in the done cycle, incl. zero-divider follow-ups
        cur_req = "R11";
        launch(1'b1, 32'd24_000_000, mkw0(250, 2, 1, 1'b0), 32'h0000_1000);
        wait_done();
        launch(1'b0, 32'd100, mkw0(4, 0, 0, 1'b0), 32'h0);
        check("R11", "err done at once", longint'(done_o && div_err_o), 1);
        launch(1'b0, 32'd100, mkw0(4, 0, 0, 1'b0), 32'h0);
        check("R11", "second err done", longint'(done_o && div_err_o), 1);
        launch(1'b0, 32'd100, mkw0(4, 1, 1, 1'b0), 32'h0);
        check("R11", "accepted busy", longint'(busy_o), 1);
        wait_done();
        check("R11", "rate 200", longint'(rate_o), 200);

        // R10/R6: outputs hold while idle
        cur_req = "R10";
        repeat (10) @(negedge clk);
        check("R10", "held rate", longint'(rate_o), 200);
        check("R6", "idle", longint'(busy_o), 0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule